// File: doc/BRIEF.md
# Serial Flash Boot Loader

This block runs once after the external reset is released. It reads a program image from a serial flash over SPI and writes it into the on-chip RAM, which holds 16-bit words. While it does this it holds the CPU in reset and drives the shared memory bus. The loader is the SPI master. It sends a read opcode with a zero start address, then shifts in a two-byte length header and the image words that follow. Each pair of bytes becomes one 16-bit word, and the words are written to consecutive RAM addresses starting at zero.

When the last word has been written, the loader raises chip select and waits a fixed number of SCK periods. On the next clock it hands the bus back and lets the CPU out of reset. A boot-mode input, sampled on the first clock after the external reset is released, skips the copy entirely. In that case the CPU is released at once and the flash is never selected.

Top module: `flash_boot_loader`

## Requirements
- R1: While `rstN` is low, `cpuRstN` is 0, `busOwn` is 1, `spiCsN` is 1, `spiSck` is 0 and `memWe` is 0.
- R2: If `skipLoad` is 1 on the first clock edge after `rstN` rises, `cpuRstN` goes to 1 and `busOwn` goes to 0 on that edge, and `spiCsN` never goes low.
- R3: The first 32 bits on `spiMosi` after chip select falls are the read opcode 0x03, followed by 24 zero address bits, most significant bit first. SPI mode 0 is used: SCK idles low, and `spiMosi` changes only while SCK is low.
- R4: SCK has a period of `CLK_DIV` clock cycles. Within each period it is high for `CLK_DIV/2` cycles and low for the remaining cycles. `spiMiso` is sampled on the rising SCK edge.
- R5: The first two bytes read after the address form the word count N, high byte first.
- R6: Exactly N memory writes follow, one per image word. Each word's first byte is bits 15:8 and its second byte is bits 7:0. The writes go to addresses 0, 1, …, N-1, and each `memWe` pulse lasts one cycle while `busOwn` is 1.
- R7: When N is 0, no memory write occurs and the loader still completes and releases the CPU.
- R8: After the final bit, `spiCsN` stays high for exactly `GAP_PERIODS × CLK_DIV` cycles before `cpuRstN` rises. On that same edge `busOwn` falls. After release there is no further SPI activity or memory write, whatever `skipLoad` does.
- R9: A load uses a single chip-select assertion that covers the command, the header and all the data. SCK toggles only while `spiCsN` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | External asynchronous reset, active low |
| skipLoad | input | 1 | Boot mode: 1 skips the copy |
| spiSck | output | 1 | SPI serial clock (mode 0) |
| spiCsN | output | 1 | Flash chip select, active low |
| spiMosi | output | 1 | Serial data to the flash |
| spiMiso | input | 1 | Serial data from the flash |
| busOwn | output | 1 | 1 while the loader owns the memory bus |
| memWe | output | 1 | One-cycle RAM write strobe |
| memAddr | output | ADDR_W | RAM word address |
| memWdata | output | WORD_W | RAM write data |
| cpuRstN | output | 1 | CPU reset, active low |

## Verification
The assertions check every cycle that SCK is high for the right number of cycles and that MOSI is stable while SCK is high. They also check that SCK toggles only under chip select, that writes occur only while the bus is owned and land on consecutive addresses from zero, that the chip-select gap before release has the right length, and that release is final. Only the bench scenarios can show the byte content of the command, the big-endian reading of the length header, the exact number and values of the written words, the zero-length image and the boot-mode skip. These checks need a flash model and the expected image.

// File: rtl/boot_pkg.sv
package boot_pkg;

  // Read opcode sent first on every load
  localparam logic [7:0] READ_OPCODE = 8'h03;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_LEN,
    ST_DATA,
    ST_GAP,
    ST_DONE
  } boot_state_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic selectChip;
    logic runSck;
    logic loadCmd;
    logic longUnit;
    logic takeLen;
    logic storeWord;
    logic runGap;
  } dp_ctl_t;

  // Status from datapath to control
  typedef struct packed {
    logic unitEnd;
    logic rxZero;
    logic lastWord;
    logic gapDone;
  } dp_stat_t;

endpackage

// File: rtl/boot_datapath.sv
module boot_datapath
  import boot_pkg::*;
#(
  parameter int CLK_DIV     = 4,
  parameter int WORD_W      = 16,
  parameter int ADDR_W      = 16,
  parameter int GAP_PERIODS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_ctl_t           ctl,
  output dp_stat_t          stat,
  input  logic              spiMiso,
  output logic              spiSck,
  output logic              spiCsN,
  output logic              spiMosi,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata
);

  localparam int CMD_W    = 32;
  localparam int DIV_W    = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int HIGH_CYC = CLK_DIV / 2;
  localparam int LOW_CYC  = CLK_DIV - HIGH_CYC;
  localparam int GAP_CYC  = GAP_PERIODS * CLK_DIV;
  localparam int GAP_W    = $clog2(GAP_CYC + 1);
  localparam int BIT_W    = $clog2(CMD_W);

  localparam logic [DIV_W-1:0] LAST_PH   = DIV_W'(CLK_DIV - 1);
  localparam logic [DIV_W-1:0] SAMPLE_PH = DIV_W'(LOW_CYC - 1);
  localparam logic [DIV_W-1:0] RISE_PH   = DIV_W'(LOW_CYC);
  localparam logic [BIT_W-1:0] LONG_LAST  = BIT_W'(CMD_W - 1);
  localparam logic [BIT_W-1:0] SHORT_LAST = BIT_W'(WORD_W - 1);
  localparam logic [GAP_W-1:0] GAP_LAST   = GAP_W'(GAP_CYC - 1);

  // SCK phase generator
  logic [DIV_W-1:0] phase, phaseNext;
  logic bitEnd, sampleNow;

  assign bitEnd    = ctl.runSck && (phase == LAST_PH);
  assign sampleNow = ctl.runSck && (phase == SAMPLE_PH);
  assign phaseNext = (!ctl.runSck || bitEnd) ? '0 : phase + 1'b1;

  logic sckQ, csNQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= '0;
      sckQ  <= 1'b0;
      csNQ  <= 1'b1;
    end else begin
      phase <= phaseNext;
      sckQ  <= ctl.runSck && (phaseNext >= RISE_PH);
      csNQ  <= !ctl.selectChip;
    end
  end

  assign spiSck = sckQ;
  assign spiCsN = csNQ;

  // Outgoing command shifter, changes only on falling SCK or at select
  logic [CMD_W-1:0] txShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      txShift <= '0;
    else if (ctl.loadCmd)
      txShift <= {READ_OPCODE, {(CMD_W-8){1'b0}}};
    else if (bitEnd)
      txShift <= {txShift[CMD_W-2:0], 1'b0};
  end

  assign spiMosi = txShift[CMD_W-1];

  // Incoming shifter, sampled on the rising SCK edge
  logic [WORD_W-1:0] rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      rxShift <= '0;
    else if (sampleNow)
      rxShift <= {rxShift[WORD_W-2:0], spiMiso};
  end

  // Bit counter within the current unit (command or 16-bit word)
  logic [BIT_W-1:0] bitCnt;
  logic lastBit;

  assign lastBit = (bitCnt == (ctl.longUnit ? LONG_LAST : SHORT_LAST));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      bitCnt <= '0;
    else if (ctl.loadCmd)
      bitCnt <= '0;
    else if (bitEnd)
      bitCnt <= lastBit ? '0 : bitCnt + 1'b1;
  end

  // Word bookkeeping and memory write port
  logic [WORD_W-1:0] remaining;
  logic [ADDR_W-1:0] addrCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remaining <= '0;
      addrCnt   <= '0;
      memWe     <= 1'b0;
      memAddr   <= '0;
      memWdata  <= '0;
    end else begin
      memWe <= ctl.storeWord;
      if (ctl.loadCmd)
        addrCnt <= '0;
      if (ctl.takeLen)
        remaining <= rxShift;
      if (ctl.storeWord) begin
        remaining <= remaining - 1'b1;
        addrCnt   <= addrCnt + 1'b1;
        memAddr   <= addrCnt;
        memWdata  <= rxShift;
      end
    end
  end

  // Deselect gap timer
  logic [GAP_W-1:0] gapCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      gapCnt <= '0;
    else if (ctl.runGap)
      gapCnt <= gapCnt + 1'b1;
    else
      gapCnt <= '0;
  end

  assign stat.unitEnd  = bitEnd && lastBit;
  assign stat.rxZero   = (rxShift == '0);
  assign stat.lastWord = (remaining == WORD_W'(1));
  assign stat.gapDone  = ctl.runGap && (gapCnt == GAP_LAST);

endmodule

// File: rtl/boot_control.sv
module boot_control
  import boot_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     skipLoad,
  input  dp_stat_t stat,
  output dp_ctl_t  ctl,
  output logic     busOwn,
  output logic     cpuRstN
);

  boot_state_t state, stateNext;
  logic releaseNow;

  always_comb begin
    ctl        = '0;
    stateNext  = state;
    releaseNow = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (skipLoad) begin
          stateNext  = ST_DONE;
          releaseNow = 1'b1;
        end else begin
          ctl.loadCmd    = 1'b1;
          ctl.selectChip = 1'b1;
          stateNext      = ST_CMD;
        end
      end
      ST_CMD: begin
        ctl.selectChip = 1'b1;
        ctl.runSck     = 1'b1;
        ctl.longUnit   = 1'b1;
        if (stat.unitEnd)
          stateNext = ST_LEN;
      end
      ST_LEN: begin
        ctl.selectChip = 1'b1;
        ctl.runSck     = 1'b1;
        if (stat.unitEnd) begin
          ctl.takeLen = 1'b1;
          if (stat.rxZero) begin
            ctl.selectChip = 1'b0;
            stateNext      = ST_GAP;
          end else begin
            stateNext = ST_DATA;
          end
        end
      end
      ST_DATA: begin
        ctl.selectChip = 1'b1;
        ctl.runSck     = 1'b1;
        if (stat.unitEnd) begin
          ctl.storeWord = 1'b1;
          if (stat.lastWord) begin
            ctl.selectChip = 1'b0;
            stateNext      = ST_GAP;
          end
        end
      end
      ST_GAP: begin
        ctl.runGap = 1'b1;
        if (stat.gapDone) begin
          stateNext  = ST_DONE;
          releaseNow = 1'b1;
        end
      end
      ST_DONE: stateNext = ST_DONE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      busOwn  <= 1'b1;
      cpuRstN <= 1'b0;
    end else begin
      state <= stateNext;
      if (releaseNow) begin
        busOwn  <= 1'b0;
        cpuRstN <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/flash_boot_loader.sv
module flash_boot_loader
  import boot_pkg::*;
#(
  parameter int CLK_DIV     = 4,
  parameter int WORD_W      = 16,
  parameter int ADDR_W      = 16,
  parameter int GAP_PERIODS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              skipLoad,
  output logic              spiSck,
  output logic              spiCsN,
  output logic              spiMosi,
  input  logic              spiMiso,
  output logic              busOwn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic              cpuRstN
);

  dp_ctl_t  ctl;
  dp_stat_t stat;

  boot_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .skipLoad (skipLoad),
    .stat     (stat),
    .ctl      (ctl),
    .busOwn   (busOwn),
    .cpuRstN  (cpuRstN)
  );

  boot_datapath #(
    .CLK_DIV     (CLK_DIV),
    .WORD_W      (WORD_W),
    .ADDR_W      (ADDR_W),
    .GAP_PERIODS (GAP_PERIODS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .stat     (stat),
    .spiMiso  (spiMiso),
    .spiSck   (spiSck),
    .spiCsN   (spiCsN),
    .spiMosi  (spiMosi),
    .memWe    (memWe),
    .memAddr  (memAddr),
    .memWdata (memWdata)
  );

endmodule

// File: rtl/flash_boot_loader_checker.sv
module flash_boot_loader_checker #(
  parameter int CLK_DIV     = 4,
  parameter int ADDR_W      = 16,
  parameter int GAP_PERIODS = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              spiSck,
  input logic              spiCsN,
  input logic              spiMosi,
  input logic              busOwn,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic              cpuRstN
);

  localparam logic [15:0] HIGH_CYC = 16'(CLK_DIV / 2);
  localparam logic [15:0] GAP_CYC  = 16'(GAP_PERIODS * CLK_DIV);

  logic [15:0]       highRun;
  logic [15:0]       csHighRun;
  logic              everSel;
  logic              haveWrite;
  logic [ADDR_W-1:0] lastAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      highRun   <= '0;
      csHighRun <= '0;
      everSel   <= 1'b0;
      haveWrite <= 1'b0;
      lastAddr  <= '0;
    end else begin
      highRun <= spiSck ? highRun + 1'b1 : '0;
      if (!spiCsN)
        csHighRun <= '0;
      else if (!cpuRstN && csHighRun != 16'hFFFF)
        csHighRun <= csHighRun + 1'b1;
      if (!spiCsN)
        everSel <= 1'b1;
      if (memWe) begin
        haveWrite <= 1'b1;
        lastAddr  <= memAddr;
      end
    end
  end

  AST_WE_OWNED: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (busOwn && !cpuRstN)); // R6

  AST_ADDR_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && !haveWrite) |-> (memAddr == '0)); // R6

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && haveWrite) |-> (memAddr == lastAddr + 1'b1)); // R6

  AST_RELEASE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    cpuRstN |=> (cpuRstN && !busOwn)); // R8

  AST_QUIET_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    cpuRstN |-> (spiCsN && !spiSck && !memWe)); // R8

  AST_CS_GAP: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(cpuRstN) && everSel) |-> (csHighRun == GAP_CYC)); // R8

  AST_SCK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rstN)
    spiSck |-> !spiCsN); // R9

  AST_MOSI_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (spiSck && $past(spiSck)) |-> $stable(spiMosi)); // R3

  AST_SCK_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(spiSck) |-> (highRun == HIGH_CYC)); // R4

endmodule

bind flash_boot_loader flash_boot_loader_checker #(
  .CLK_DIV     (CLK_DIV),
  .ADDR_W      (ADDR_W),
  .GAP_PERIODS (GAP_PERIODS)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .spiSck  (spiSck),
  .spiCsN  (spiCsN),
  .spiMosi (spiMosi),
  .busOwn  (busOwn),
  .memWe   (memWe),
  .memAddr (memAddr),
  .cpuRstN (cpuRstN)
);

// File: tb/flash_boot_loader_test.sv
module flash_boot_loader_test;

  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int GAP_P      = 2;
  localparam int HIGH       = DIV / 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        skipLoad = 1'b0;
  logic        spiSck, spiCsN, spiMosi;
  logic        spiMiso;
  logic        busOwn, memWe, cpuRstN;
  logic [15:0] memAddr, memWdata;

  flash_boot_loader #(.CLK_DIV(DIV), .GAP_PERIODS(GAP_P)) uut (
    .clk(clk), .rstN(rstN), .skipLoad(skipLoad),
    .spiSck(spiSck), .spiCsN(spiCsN), .spiMosi(spiMosi), .spiMiso(spiMiso),
    .busOwn(busOwn), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .cpuRstN(cpuRstN)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0;
  int checks = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Flash model: image bytes, command capture, mode 0 output
  logic [7:0]  img [0:1023];
  logic [31:0] cmdCap = '0;
  int          inCnt = 0;
  int          outIdx = 0;
  logic        sckSeen = 1'b0;
  logic        misoQ = 1'b0;

  function automatic logic imgBit(input int idx);
    logic [7:0] b;
    b = (idx / 8 < 1024) ? img[idx / 8] : 8'hFF;
    return b[7 - (idx % 8)];
  endfunction

  always @(spiSck or spiCsN) begin
    if (spiCsN) begin
      inCnt  = 0;
      outIdx = 0;
    end else if (spiSck && !sckSeen) begin
      if (inCnt < 32) begin
        cmdCap = {cmdCap[30:0], spiMosi};
        inCnt++;
      end
    end else if (!spiSck && sckSeen) begin
      if (inCnt >= 32) begin
        misoQ = imgBit(outIdx);
        outIdx++;
      end
    end
    sckSeen = spiSck;
  end

  assign spiMiso = misoQ;

  function automatic logic [15:0] expWord(input int i);
    return 16'(i * 40503 + 23100);
  endfunction

  task automatic buildImage(input int n);
    for (int i = 0; i < 1024; i++) img[i] = 8'hFF;
    img[0] = 8'(n >> 8);
    img[1] = 8'(n);
    for (int i = 0; i < n; i++) begin
      img[2 + 2*i] = expWord(i)[15:8];
      img[3 + 2*i] = expWord(i)[7:0];
    end
  endtask

  // Port monitor
  logic        monClear = 1'b1;
  logic [15:0] bmem [0:1023];
  int writes, addrBad, lateWrites, csFalls, gapCyc, mosiBad;
  int minPer, maxPer, minHigh, maxHigh, highRun, lastRise, cyc;
  logic prevSck, prevCs, prevMosi;

  always @(posedge clk) begin
    if (monClear) begin
      writes = 0; addrBad = 0; lateWrites = 0; csFalls = 0; gapCyc = 0;
      mosiBad = 0; minPer = 1 << 30; maxPer = 0; minHigh = 1 << 30; maxHigh = 0;
      highRun = 0; lastRise = -1; cyc = 0;
      prevSck = 1'b0; prevCs = 1'b1; prevMosi = 1'b0;
    end else begin
      if (memWe) begin
        if (cpuRstN) lateWrites++;
        if (memAddr < 16'd1024) bmem[memAddr[9:0]] = memWdata;
        if (int'(memAddr) != writes) addrBad++;
        writes++;
      end
      if (prevCs && !spiCsN) csFalls++;
      if (spiCsN && !cpuRstN && csFalls > 0) gapCyc++;
      if (spiSck && !prevSck) begin
        if (lastRise >= 0) begin
          if (cyc - lastRise < minPer) minPer = cyc - lastRise;
          if (cyc - lastRise > maxPer) maxPer = cyc - lastRise;
        end
        lastRise = cyc;
      end
      if (spiSck) highRun++;
      else if (prevSck) begin
        if (highRun < minHigh) minHigh = highRun;
        if (highRun > maxHigh) maxHigh = highRun;
        highRun = 0;
      end
      if (spiSck && prevSck && spiMosi != prevMosi) mosiBad++;
      cyc++;
      prevSck = spiSck; prevCs = spiCsN; prevMosi = spiMosi;
    end
  end

  task automatic startRun(input logic skip);
    @(negedge clk);
    rstN = 1'b0;
    skipLoad = skip;
    monClear = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    monClear = 1'b0;
  endtask

  task automatic testReset();
    @(negedge clk);
    rstN = 1'b0;
    monClear = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "cpuRstN in reset", cpuRstN, 0);
    chk("R1", "busOwn in reset", busOwn, 1);
    chk("R1", "spiCsN in reset", spiCsN, 1);
    chk("R1", "spiSck in reset", spiSck, 0);
    chk("R1", "memWe in reset", memWe, 0);
  endtask

  task automatic testSkip();
    startRun(1'b1);
    @(negedge clk);
    chk("R2", "cpuRstN after first edge", cpuRstN, 1);
    chk("R2", "busOwn after first edge", busOwn, 0);
    for (int i = 0; i < 40; i++) begin
      skipLoad = i[0];
      @(negedge clk);
    end
    chk("R2", "chip select falls", csFalls, 0);
    chk("R2", "memory writes", writes, 0);
    chk("R2", "cpuRstN stays released", cpuRstN, 1);
  endtask

  task automatic testLoad(input int n);
    int waited;
    int bad;
    buildImage(n);
    startRun(1'b0);
    waited = 0;
    while (!cpuRstN && waited < 60000) begin
      @(negedge clk);
      waited++;
    end
    chk("R8", "released before timeout", cpuRstN, 1);
    chk("R3", "command word", cmdCap, 32'h0300_0000);
    chk("R3", "mosi changes while sck high", mosiBad, 0);
    chk("R4", "min sck period", minPer, DIV);
    chk("R4", "max sck period", maxPer, DIV);
    chk("R4", "min sck high", minHigh, HIGH);
    chk("R4", "max sck high", maxHigh, HIGH);
    if (n == 0) chk("R7", "writes for empty image", writes, 0);
    else if (n > 255) chk("R5", "writes for big-endian count", writes, n);
    else chk("R6", "write count", writes, n);
    chk("R6", "address sequence errors", addrBad, 0);
    bad = 0;
    for (int i = 0; i < n && i < 1024; i++)
      if (bmem[i] !== expWord(i)) bad++;
    chk("R6", "word content mismatches", bad, 0);
    chk("R9", "chip select assertions", csFalls, 1);
    chk("R8", "deselect gap cycles", gapCyc, GAP_P * DIV);
    chk("R8", "busOwn after release", busOwn, 0);
    for (int i = 0; i < 40; i++) begin
      skipLoad = i[1];
      @(negedge clk);
    end
    chk("R8", "writes after release", lateWrites, 0);
    chk("R8", "chip select after release", csFalls, 1);
    chk("R8", "cpuRstN stays released", cpuRstN, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    testReset();
    testSkip();
    testLoad(5);
    testLoad(1);
    testLoad(0);
    testLoad(258);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule